// File: doc/BRIEF.md
# Eight-Channel Endpoint DMA Engine

This block moves 32-bit words between system memory and the endpoint FIFOs of a USB device controller. It has eight channels. Each channel is tied by software to one endpoint and one direction. In the transmit direction a channel reads memory and pushes the words into the endpoint FIFO. In the receive direction it pops the FIFO and writes memory. Software programs the channels through a small register port with per-byte strobes. The engine has one memory master port and one FIFO data port, and both are shared by all channels.

Each channel exposes three registers: a start address, a byte count and a 16-bit control word. A status byte at the base of the window collects one pending bit per channel. Software writes the address and the count, then sets the enable bit in the control word. As the channel runs, its address register moves forward and its count register moves down. A finished channel therefore reads count zero, and the number of bytes moved is the current address minus the start address. If the memory port reports an error, the channel stops with its error flag set. Either way, it raises its pending bit. The interrupt output fires for any pending channel whose interrupt enable is set.

Top module: `usb_dma_engine`

## Requirements
- R1: After reset every address, count and control register reads 0, the status byte reads 0, and `irq` and `mem_req` are low.
- R2: The registers sit at byte address 0x200 + 16·n + {0x4 control, 0x8 address, 0xC count}. Writes touch only the bytes whose `reg_be` bit is set. The two low address bits always read 0. The control word holds enable (bit 0), transmit (bit 1), mode 1 (bit 2), interrupt enable (bit 3), endpoint (bits 7:4), bus error (bit 8, read-only) and burst type (bits 10:9). Its other bits read 0.
- R3: In transmit, an enabled channel reads words from consecutive memory addresses and pushes them to its endpoint's FIFO. Each word adds 4 to the address and takes 4 from the count, but never below 0. When the count reaches 0, enable clears and status bit n is set. A channel enabled with count 0 completes at once.
- R4: In receive (transmit bit 0), each FIFO word popped from the channel's endpoint is written to memory at the current address, with the same address and count advance as in transmit.
- R5: Burst type 0 gives one beat per grant, 1 gives 4, 2 gives 8 and 3 gives 16. Beats are capped at the words remaining, and a grant serves only one channel. Between grants `mem_req` drops for at least one cycle.
- R6: Among channels that are eligible in the same cycle, the lowest channel number is granted first.
- R7: A channel is eligible only while it is enabled, its count is non-zero and `ep_req` for its endpoint is high. A channel whose request line is low moves no data.
- R8: A beat answered with `mem_err` does not advance that channel's address or count. It sets the channel's bus-error bit, clears its enable, ends the grant and sets its status bit.
- R9: A read of the status byte (0x200) returns the pending bits and clears them in the same access. A bit that is set in the same cycle stays set. `irq` is the OR of the pending bits whose channel has interrupt enable set.
- R10: Writing 0 to a channel's control word stops it: no beat of that channel follows the write's clock edge, and no status bit is raised. Address and count can then be written to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the status clear) |
| reg_addr | input | RAW | Register byte address |
| reg_be | input | 4 | Byte strobes for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the address |
| irq | output | 1 | Interrupt |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 for a memory write (receive), 0 for a memory read |
| mem_addr | output | AW | Word-aligned memory byte address |
| mem_burst | output | 2 | Burst type of the granted channel |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the beat cycle |
| mem_ack | input | 1 | A beat completes in a cycle when `mem_req` and `mem_ack` are both high |
| mem_err | input | 1 | Error response for the current beat |
| ep_req | input | 16 | Per-endpoint request lines |
| fifo_ep | output | 4 | Endpoint selected on the FIFO port |
| fifo_push | output | 1 | Push `fifo_wdata` into the endpoint FIFO |
| fifo_wdata | output | 32 | Word for the endpoint FIFO |
| fifo_pop | output | 1 | Pop the head word of the endpoint FIFO |
| fifo_rdata | input | 32 | Head word of the selected endpoint FIFO |

## Verification
The bench builds the engine with its default parameters: eight channels, a 12-bit register address and 32-bit address and count registers. With these values every channel slot, all four burst types and the full endpoint field can be reached. Directed cases cover the following:
- two channels that become eligible in the same cycle, to check priority and the grant count per burst type;
- a channel held back by its request line;
- a fault injected on the third beat;
- an abort during a long transfer;
- a channel enabled with count zero.

Random transfers then vary the channel, direction, burst type and length, with random memory acknowledge stalls.

// File: rtl/usb_dma_engine.sv
module usb_dma_engine #(
  parameter int NCH  = 8,
  parameter int AW   = 32,
  parameter int CW   = 32,
  parameter int RAW  = 12,
  parameter int BASE = 'h200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [RAW-1:0]  reg_addr,
  input  logic [3:0]      reg_be,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            irq,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_burst,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic [15:0]     ep_req,
  output logic [3:0]      fifo_ep,
  output logic            fifo_push,
  output logic [31:0]     fifo_wdata,
  output logic            fifo_pop,
  input  logic [31:0]     fifo_rdata
);
  localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SPAN = NCH * 16;

  logic [NCH-1:0] en, tx, md, ie, berr, pend, elig, setv;
  logic [3:0]     ep   [NCH];
  logic [1:0]     bt   [NCH];
  logic [AW-1:0]  adr  [NCH];
  logic [CW-1:0]  cnt  [NCH];
  logic [15:0]    ctlv [NCH];
  logic           bsy, any;
  logic [CHW-1:0] cur, win;
  logic [4:0]     left;

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] w,
                                      input logic [3:0] b);
    for (int i = 0; i < 4; i++) mrg[8*i +: 8] = b[i] ? w[8*i +: 8] : o[8*i +: 8];
  endfunction

  function automatic logic [4:0] blen(input logic [1:0] t);
    case (t)
      2'd1:    blen = 5'd4;
      2'd2:    blen = 5'd8;
      2'd3:    blen = 5'd16;
      default: blen = 5'd1;
    endcase
  endfunction

  wire [RAW:0]    roff   = {1'b0, reg_addr} - (RAW+1)'(BASE);
  wire            in_win = !roff[RAW] && (roff < (RAW+1)'(SPAN));
  wire [CHW-1:0]  rch    = roff[4 +: CHW];
  wire [1:0]      rsel   = roff[3:2];
  wire            rd_st  = reg_rd && in_win && (roff == '0);
  wire            wr_ctl = reg_wr && in_win && (rsel == 2'd1);
  wire            wr_adr = reg_wr && in_win && (rsel == 2'd2);
  wire            wr_cnt = reg_wr && in_win && (rsel == 2'd3);

  wire [7:0]      wlo  = reg_be[0] ? reg_wdata[7:0] : ctlv[rch][7:0];
  wire [1:0]      wbt  = reg_be[1] ? reg_wdata[10:9] : bt[rch];
  wire [AW-1:0]   wadr = AW'(mrg(32'(adr[rch]), reg_wdata, reg_be)) & ~AW'(3);
  wire [CW-1:0]   wcnt = CW'(mrg(32'(cnt[rch]), reg_wdata, reg_be));

  wire            beat  = mem_req && mem_ack;
  wire [CW-1:0]   ccur  = cnt[cur];
  wire [CW-1:0]   cnext = (ccur < CW'(4)) ? '0 : ccur - CW'(4);
  wire [CW-1:0]   wwin  = (cnt[win] >> 2) + CW'(|cnt[win][1:0]);
  wire [4:0]      bwin  = blen(bt[win]);
  wire [4:0]      first = (wwin < CW'(bwin)) ? wwin[4:0] : bwin;

  always_comb begin
    for (int c = 0; c < NCH; c++)
      ctlv[c] = {5'b0, bt[c], berr[c], ep[c], ie[c], md[c], tx[c], en[c]};
  end

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      elig[c] = en[c] && (cnt[c] != '0) && ep_req[ep[c]];
      if (elig[c]) begin
        any = 1'b1;
        win = CHW'(c);
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++)
      setv[c] = (en[c] && (cnt[c] == '0) && !(bsy && cur == CHW'(c))) ||
                (beat && cur == CHW'(c) && (mem_err || cnext == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bsy  <= 1'b0;
      cur  <= '0;
      left <= '0;
      pend <= '0;
      en   <= '0;
      tx   <= '0;
      md   <= '0;
      ie   <= '0;
      berr <= '0;
      for (int c = 0; c < NCH; c++) begin
        ep[c]  <= '0;
        bt[c]  <= '0;
        adr[c] <= '0;
        cnt[c] <= '0;
      end
    end else begin
      pend <= (rd_st ? '0 : pend) | setv;
      if (!bsy) begin
        if (any) begin
          bsy  <= 1'b1;
          cur  <= win;
          left <= first;
        end
      end else begin
        if (!en[cur] || (beat && (mem_err || left == 5'd1 || cnext == '0)))
          bsy <= 1'b0;
        if (beat)
          left <= left - 5'd1;
      end
      for (int c = 0; c < NCH; c++) begin
        if (setv[c])
          en[c] <= 1'b0;
        if (beat && cur == CHW'(c)) begin
          if (mem_err)
            berr[c] <= 1'b1;
          else begin
            adr[c] <= adr[c] + AW'(4);
            cnt[c] <= cnext;
          end
        end
        if (rch == CHW'(c)) begin
          if (wr_ctl) begin
            en[c]   <= wlo[0];
            tx[c]   <= wlo[1];
            md[c]   <= wlo[2];
            ie[c]   <= wlo[3];
            ep[c]   <= wlo[7:4];
            bt[c]   <= wbt;
            berr[c] <= 1'b0;
          end
          if (wr_adr) adr[c] <= wadr;
          if (wr_cnt) cnt[c] <= wcnt;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (in_win) begin
      case (rsel)
        2'd0:    if (rch == '0) reg_rdata = 32'(pend);
        2'd1:    reg_rdata = 32'(ctlv[rch]);
        2'd2:    reg_rdata = 32'(adr[rch]);
        default: reg_rdata = 32'(cnt[rch]);
      endcase
    end
  end

  assign irq        = |(pend & ie);
  assign mem_req    = bsy && en[cur];
  assign mem_we     = !tx[cur];
  assign mem_addr   = adr[cur];
  assign mem_burst  = bt[cur];
  assign mem_wdata  = fifo_rdata;
  assign fifo_ep    = ep[cur];
  assign fifo_wdata = mem_rdata;
  assign fifo_push  = beat && tx[cur] && !mem_err;
  assign fifo_pop   = beat && !tx[cur] && !mem_err;
endmodule

// File: rtl/usb_dma_engine_chk.sv
module usb_dma_engine_chk #(
  parameter int NCH = 8,
  parameter int AW  = 32,
  parameter int CHW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_err,
  input logic [AW-1:0]   mem_addr,
  input logic            bsy,
  input logic [CHW-1:0]  cur,
  input logic [NCH-1:0]  elig,
  input logic [NCH-1:0]  en,
  input logic [NCH-1:0]  pend,
  input logic [NCH-1:0]  setv,
  input logic            rd_st
);
  logic [5:0] nbeat;
  always_ff @(posedge clk) begin
    if (!rst_n || !bsy) nbeat <= '0;
    else if (mem_req && mem_ack) nbeat <= nbeat + 6'd1;
  end

  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !mem_err) |=> (!mem_req || mem_addr == $past(mem_addr) + AW'(4)));

  assert_one_channel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && $past(bsy)) |-> $stable(cur));

  assert_burst_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nbeat <= 6'd16);

  assert_lowest_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy) |-> (($past(elig) & ((NCH'(1) << cur) - NCH'(1))) == '0));

  assert_grant_eligible_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy) |-> (($past(elig) >> cur) & NCH'(1)) != '0);

  assert_err_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> !mem_req);

  assert_pend_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_st |=> ((pend & $past(pend)) == $past(pend)));

  assert_pend_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_st && setv == '0) |=> pend == '0);

  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy && !en[cur]) |=> !mem_req);
endmodule

bind usb_dma_engine usb_dma_engine_chk #(.NCH(NCH), .AW(AW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_ack(mem_ack), .mem_err(mem_err),
  .mem_addr(mem_addr), .bsy(bsy), .cur(cur), .elig(elig), .en(en), .pend(pend),
  .setv(setv), .rd_st(rd_st)
);

// File: tb/test_usb_dma_engine.sv
`timescale 1ns/1ps
module test_usb_dma_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = 0;
  logic [3:0]  reg_be = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq, mem_req, mem_we, mem_ack = 0, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, fifo_wdata, fifo_rdata;
  logic [1:0]  mem_burst;
  logic [15:0] ep_req = '1;
  logic [3:0]  fifo_ep;
  logic        fifo_push, fifo_pop;

  usb_dma_engine i_usb_dma_engine (.*);

  int n_chk = 0, n_bad = 0;
  bit [31:0] memm [0:1023];
  int txn [16];
  int rxn [16];
  bit [31:0] txlog [16][0:511];
  int nb = 0, rises = 0;
  bit [3:0] blog [0:63];
  bit req_q = 0, ack_all = 0, err_on = 0;
  bit [31:0] err_a = 0;

  assign mem_rdata  = memm[mem_addr[11:2]];
  assign mem_err    = err_on && mem_req && (mem_addr == err_a);
  assign fifo_rdata = {fifo_ep, 12'h0, rxn[fifo_ep][15:0]};

  always @(negedge clk) mem_ack <= ack_all || ($urandom % 4 != 0);

  always @(posedge clk) begin
    if (mem_req && mem_ack && mem_we && !mem_err) memm[mem_addr[11:2]] <= mem_wdata;
    if (fifo_push) begin
      txlog[fifo_ep][txn[fifo_ep]] <= fifo_wdata;
      txn[fifo_ep] <= txn[fifo_ep] + 1;
    end
    if (fifo_pop) rxn[fifo_ep] <= rxn[fifo_ep] + 1;
    if (mem_req && mem_ack) begin
      blog[nb % 64] <= fifo_ep;
      nb <= nb + 1;
    end
    if (mem_req && !req_q) rises <= rises + 1;
    req_q <= mem_req;
  end

  function automatic bit [31:0] pat(input int i);
    return (i * 32'h9E3779B1) ^ 32'h55;
  endfunction
  function automatic bit [31:0] rxw(input int e, input int k);
    return {4'(e), 12'h0, 16'(k)};
  endfunction
  function automatic bit [31:0] cfg(input bit t, input bit m, input bit i, input int e, input int b);
    return {21'b0, 2'(b), 1'b0, 4'(e), i, m, t, 1'b1};
  endfunction
  function automatic bit [11:0] ra(input int ch, input int o);
    return 12'(32'h200 + ch * 16 + o);
  endfunction

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit [11:0] a, input bit [31:0] d, input bit [3:0] be);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input bit [11:0] a, output bit [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic prog(input int ch, input bit [31:0] a, input bit [31:0] c, input bit [31:0] k);
    wr(ra(ch, 8), a, 4'hF);
    wr(ra(ch, 12), c, 4'hF);
    wr(ra(ch, 4), k, 4'h3);
  endtask

  task automatic wait_idle(input int ch, input string tag);
    bit [31:0] v;
    for (int t = 0; t < 4000; t++) begin
      rd(ra(ch, 4), v);
      if (!v[0]) return;
    end
    check({tag, " timeout"}, 1, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #1200000;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit [31:0] v;
    int t0, r0, nb0, rs0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) memm[i] = pat(i);
    for (int i = 0; i < 16; i++) begin txn[i] = 0; rxn[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 mem_req", mem_req, 0);
    rd(ra(0, 0), v);  check("R1 status", v, 0);
    rd(ra(0, 4), v);  check("R1 ctl0", v, 0);
    rd(ra(7, 12), v); check("R1 cnt7", v, 0);
    rd(ra(5, 8), v);  check("R1 adr5", v, 0);

    // R2 decode, strobes, alignment
    wr(ra(0, 8), 32'h1003, 4'hF); rd(ra(0, 8), v); check("R2 addr align", v, 32'h1000);
    wr(ra(0, 12), 32'h12345678, 4'hF);
    wr(ra(0, 12), 32'hAABBCCDD, 4'b0100); rd(ra(0, 12), v); check("R2 byte strobe", v, 32'h12BB5678);
    wr(ra(0, 4), 32'hFFFF_06F6, 4'h3); rd(ra(0, 4), v); check("R2 ctl fields", v, 32'h06F6);
    wr(ra(0, 4), 32'h0000_0100, 4'h3); rd(ra(0, 4), v); check("R2 berr read-only", v, 0);
    wr(ra(0, 12), 0, 4'hF);

    // R3 transmit, 10 words, burst 4, irq enabled
    t0 = txn[5];
    prog(2, 32'h40, 40, cfg(1, 1, 1, 5, 1));
    wait_idle(2, "R3");
    repeat (2) @(negedge clk);
    check("R3 words pushed", txn[5] - t0, 10);
    for (int k = 0; k < 10; k++) check("R3 tx data", txlog[5][t0 + k], pat(16 + k));
    rd(ra(2, 8), v);  check("R3 end addr", v, 32'h68);
    rd(ra(2, 12), v); check("R3 count zero", v, 0);
    check("R9 irq raised", irq, 1);
    rd(ra(0, 0), v);  check("R9 status bit2", v, 32'h04);
    check("R9 irq after clear", irq, 0);
    rd(ra(0, 0), v);  check("R9 status cleared", v, 0);

    // R3 zero count completes at once
    prog(3, 32'h80, 0, cfg(1, 0, 0, 3, 0));
    repeat (3) @(negedge clk);
    rd(ra(3, 4), v); check("R3 zero-count enable", v[0], 0);
    rd(ra(0, 0), v); check("R3 zero-count status", v, 32'h08);

    // R4 receive, 6 words, single beats, irq masked
    r0 = rxn[3];
    prog(0, 32'h100, 24, cfg(0, 0, 0, 3, 0));
    wait_idle(0, "R4");
    repeat (2) @(negedge clk);
    for (int k = 0; k < 6; k++) check("R4 rx data", memm[64 + k], rxw(3, r0 + k));
    rd(ra(0, 8), v); check("R4 end addr", v, 32'h118);
    check("R9 irq masked", irq, 0);
    rd(ra(0, 0), v); check("R9 masked status bit0", v, 32'h01);

    // R5 / R6 priority and grant lengths
    ack_all = 1;
    ep_req = '0;
    prog(4, 32'h4B0, 8, cfg(1, 0, 0, 4, 0));
    prog(1, 32'h500, 64, cfg(1, 1, 0, 1, 2));
    @(negedge clk);
    nb0 = nb; rs0 = rises;
    ep_req = '1;
    wait_idle(4, "R6");
    wait_idle(1, "R6");
    repeat (2) @(negedge clk);
    check("R6 beat count", nb - nb0, 18);
    for (int k = 0; k < 16; k++) check("R6 ch1 first", blog[(nb0 + k) % 64], 1);
    check("R6 ch4 last", blog[(nb0 + 16) % 64], 4);
    check("R5 grants", rises - rs0, 4);
    for (int k = 0; k < 16; k++) check("R5 burst data", txlog[1][txn[1] - 16 + k], pat(320 + k));
    ack_all = 0;
    rd(ra(0, 0), v);

    // R7 pacing
    t0 = txn[9];
    ep_req[9] = 0;
    prog(5, 32'h600, 12, cfg(1, 0, 0, 9, 3));
    repeat (50) @(negedge clk);
    rd(ra(5, 12), v); check("R7 held count", v, 12);
    check("R7 no push", txn[9] - t0, 0);
    ep_req[9] = 1;
    wait_idle(5, "R7");
    rd(ra(5, 12), v); check("R7 released", v, 0);
    rd(ra(0, 0), v);

    // R8 bus error on third word
    err_on = 1; err_a = 32'h208;
    t0 = txn[6];
    prog(6, 32'h200, 16, cfg(1, 0, 1, 6, 1));
    wait_idle(6, "R8");
    repeat (2) @(negedge clk);
    err_on = 0;
    rd(ra(6, 4), v);  check("R8 ctl", v, (cfg(1, 0, 1, 6, 1) & ~32'h1) | 32'h100);
    rd(ra(6, 8), v);  check("R8 addr held", v, 32'h208);
    rd(ra(6, 12), v); check("R8 count held", v, 8);
    check("R8 pushes", txn[6] - t0, 2);
    check("R8 irq", irq, 1);
    rd(ra(0, 0), v);  check("R8 status", v, 32'h40);

    // R10 abort
    t0 = txn[7];
    prog(7, 32'h800, 1600, cfg(1, 0, 1, 7, 3));
    repeat (30) @(negedge clk);
    wr(ra(7, 4), 0, 4'h3);
    r0 = txn[7];
    wr(ra(7, 8), 0, 4'hF);
    wr(ra(7, 12), 0, 4'hF);
    repeat (30) @(negedge clk);
    check("R10 started", (r0 - t0) > 0, 1);
    check("R10 no beat after", txn[7], r0);
    check("R10 mem_req low", mem_req, 0);
    rd(ra(7, 12), v); check("R10 count", v, 0);
    rd(ra(0, 0), v);  check("R10 no status", v, 0);

    // random transfers
    for (int it = 0; it < 6; it++) begin
      int ch, w, b, base;
      bit t;
      ch = $urandom % 8; t = $urandom % 2; b = $urandom % 4;
      w = 1 + $urandom % 20; base = 512 + it * 32;
      t0 = txn[ch]; r0 = rxn[ch];
      prog(ch, base * 4, w * 4, cfg(t, t, 1, ch, b));
      wait_idle(ch, "R3 random");
      repeat (2) @(negedge clk);
      rd(ra(ch, 8), v);  check("R3 random end addr", v, (base + w) * 4);
      rd(ra(ch, 12), v); check("R3 random count", v, 0);
      if (t) begin
        check("R3 random pushes", txn[ch] - t0, w);
        for (int k = 0; k < w; k++) check("R3 random tx", txlog[ch][t0 + k], pat(base + k));
      end else begin
        for (int k = 0; k < w; k++) check("R4 random rx", memm[base + k], rxw(ch, r0 + k));
      end
      rd(ra(0, 0), v); check("R9 random status", v, 32'(1) << ch);
    end

    summary();
    $finish;
  end
endmodule